// File: doc/BRIEF.md
# Temperature Sensor Conversion Controller

This block sits between a software-written control word and an on-chip analog temperature sensor. Software writes three control bits: a core reset release, a power-down request and a conversion request. The controller turns them into sequencing signals for the analog core. It will not release the core reset until the analog supply has been up for a programmed number of cycles, and until the reset has then been held for a further minimum time.

Once the core is ready, the controller schedules conversions on a fixed sample period and captures the 12-bit raw code from the analog side at the end of each period. It reports every finished sample through a pending interrupt flag. A short pulse on the request bit gives exactly one conversion, and holding the bit gives a conversion every period. Requests made before the core is ready are dropped and recorded in a sticky error flag. Completions that arrive while the interrupt is still pending are counted.

Top module: `tsense_ctrl`

## Requirements
- R1: After reset, `sense_pd` is 1, `sense_rst_n` is 0, `irq` is 0, `ovf_count` is 0 and `status_word` is all zeros.
- R2: Assume the release bit is 1 and power-down is 0 from the write at clock edge E0. Then `sense_rst_n` and status bit 0 (ready) rise at edge E0+PU_CYCLES+RST_CYCLES+1, and not at any earlier edge. This covers PU_CYCLES of power-up time and RST_CYCLES of reset held after power-up.
- R3: Control word encoding: bit 0 = 1 releases the core reset, bit 1 = 1 powers the core down (`sense_pd` follows it one cycle after the write), and bit 2 = 1 requests conversions.
- R4: A request bit written 1 and then 0 on the next cycle gives exactly one conversion. The request must be written while ready. The conversion completes at edge W+SAMPLE_CYCLES+1, where W is the edge that set the bit, and it runs to completion although the bit has dropped.
- R5: While the request bit stays 1, completions repeat every SAMPLE_CYCLES cycles.
- R6: At each completion the raw code is captured into `status_word[27:16]`. The field holds that value until the next completion.
- R7: Every completion sets `irq`. A pulse on `irq_ack` clears it, and a completion in the same cycle as the clear leaves it set.
- R8: A completion while `irq` is already set and not being cleared increments `ovf_count`, which saturates at its maximum.
- R9: A write with bit 2 set while ready is 0 is ignored: no conversion follows, even after the core becomes ready. Status bit 3 (error) is set and stays set until an `err_ack` pulse.
- R10: Power-down or reset written while a conversion is running drops ready on the next edge and aborts the conversion with no completion. The request is cleared, so no conversion resumes on re-power.
- R11: Status bit 1 (busy) is 1 exactly while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit0 release, bit1 power-down, bit2 request |
| irq_ack | input | 1 | Write-one pulse clearing the pending interrupt |
| err_ack | input | 1 | Write-one pulse clearing the error flag |
| raw_code | input | 12 | Raw conversion code from the analog core |
| sense_pd | output | 1 | Power-down to the analog core |
| sense_rst_n | output | 1 | Active-low reset to the analog core |
| status_word | output | 32 | [27:16] result, [3] error, [2] pending, [1] busy, [0] ready |
| irq | output | 1 | Conversion-done interrupt level |
| ovf_count | output | OVF_W | Saturating count of completions missed while pending |

## Verification
Corrupted power-up or reset-hold counters show up at once as a ready edge that moves by one or more cycles from the computed edge, so the bench samples ready on the cycle before the edge and on the cycle of the edge. A wrong sample counter or state shows up as a result change or interrupt one or more cycles away from W+SAMPLE_CYCLES+1, or as an extra completion after a single shot. A lost request or abort bit shows up within one sample period as an unexpected completion or a stale result. The overflow count exposes a faulty pending bit by the second completion.

// File: rtl/tsense_pkg.sv
// Shared types for the temperature sensor conversion controller.
// Assumes the control word layout is fixed by software: bit0 release,
// bit1 power-down, bit2 request.
package tsense_pkg;

    localparam int CODE_W  = 12;
    localparam int RES_LSB = 16;

    typedef struct packed {
        logic run;  // bit 2: conversion request
        logic pd;   // bit 1: analog power-down
        logic rel;  // bit 0: core reset release (0 keeps reset)
    } ctl_t;

    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_BUSY = 1'b1
    } conv_st_e;

endpackage

// File: rtl/tsense_pwr.sv
// Power and reset sequencer. Counts PU_CYCLES after power-down clears, then
// holds the core reset RST_CYCLES more before ready may rise. Assumes pd and
// rel come from a register; ready drops one edge after pd or !rel appear.
module tsense_pwr #(
    parameter int PU_CYCLES  = 5000,
    parameter int RST_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic rel,
    output logic ready
);
    localparam int PU_W  = $clog2(PU_CYCLES + 1);
    localparam int RST_W = $clog2(RST_CYCLES + 1);
    localparam logic [PU_W-1:0]  PU_LAST  = PU_W'(PU_CYCLES);
    localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_CYCLES);

    logic [PU_W-1:0]  pu_cnt;
    logic [RST_W-1:0] hold_cnt;
    logic             pwr_ok;
    logic             ready_q;

    assign pwr_ok = (pu_cnt == PU_LAST);

    // Power-up timer: restarts while powered down, stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || pd)
            pu_cnt <= '0;
        else if (!pwr_ok)
            pu_cnt <= pu_cnt + PU_W'(1);
    end

    // Reset hold timer: runs while powered and the core is still in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok || ready_q)
            hold_cnt <= '0;
        else if (hold_cnt != RST_LAST)
            hold_cnt <= hold_cnt + RST_W'(1);
    end

    // Ready register: release only after both timers have expired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= rel && !pd && pwr_ok && (ready_q || hold_cnt == RST_LAST);
    end

    assign ready = ready_q;

    assert_ready_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> (pu_cnt == PU_LAST));
    assert_reset_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> ($past(hold_cnt) == RST_LAST));

endmodule

// File: rtl/tsense_conv.sv
// Sample scheduler. Starts a conversion when requested and ready, finishes it
// after SAMPLE_CYCLES cycles, and captures the raw code at that moment.
// Assumes raw_code is valid from the analog side when the period ends.
module tsense_conv
    import tsense_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 819200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              run,
    input  logic [CODE_W-1:0] raw_code,
    output logic              fin,
    output logic              busy,
    output logic [CODE_W-1:0] result
);
    localparam int CNT_W = $clog2(SAMPLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYCLES - 1);

    conv_st_e          st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] result_q;

    assign fin  = (st_q == CONV_BUSY) && ready && (cnt_q == CNT_LAST);
    assign busy = (st_q == CONV_BUSY);

    // Conversion state and period counter; an in-flight sample ignores run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CONV_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                CONV_IDLE: begin
                    cnt_q <= '0;
                    if (run && ready)
                        st_q <= CONV_BUSY;
                end
                default: begin
                    if (!ready) begin
                        st_q  <= CONV_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        st_q  <= run ? CONV_BUSY : CONV_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Result register: loaded only at the end of a sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (fin)
            result_q <= raw_code;
    end

    assign result = result_q;

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(result_q));
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (st_q == CONV_IDLE));

endmodule

// File: rtl/tsense_irq.sv
// Completion interrupt. A pending level set by each finished sample and
// cleared by a write-one pulse, plus a saturating count of completions that
// land while the level is still pending. Set wins over clear.
module tsense_irq #(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin,
    input  logic             ack,
    output logic             pend,
    output logic [OVF_W-1:0] ovf
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    logic             pend_q;
    logic [OVF_W-1:0] ovf_q;

    // Pending flag: a completion sets it, an ack clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= fin || (pend_q && !ack);
    end

    // Overflow counter: counts completions that find the flag still set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (fin && pend_q && !ack && ovf_q != OVF_MAX)
            ovf_q <= ovf_q + OVF_W'(1);
    end

    assign pend = pend_q;
    assign ovf  = ovf_q;

    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> pend_q);
    assert_ovf_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && pend_q && !ack && ovf_q != OVF_MAX) |=> (ovf_q == $past(ovf_q) + OVF_W'(1)));

endmodule

// File: rtl/tsense_ctrl.sv
// Top of the temperature sensor conversion controller. Holds the control
// word and the sticky error flag, and wires the power sequencer, the sample
// scheduler and the interrupt logic. Cycle counts derive from CLK_MHZ
// unless overridden.
module tsense_ctrl
    import tsense_pkg::*;
#(
    parameter int CLK_MHZ       = 100,
    parameter int PU_CYCLES     = 50 * CLK_MHZ,
    parameter int RST_CYCLES    = (CLK_MHZ * 100 + 999) / 1000,
    parameter int SAMPLE_CYCLES = 8192 * CLK_MHZ,
    parameter int OVF_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_wdata,
    input  logic              irq_ack,
    input  logic              err_ack,
    input  logic [CODE_W-1:0] raw_code,
    output logic              sense_pd,
    output logic              sense_rst_n,
    output logic [31:0]       status_word,
    output logic              irq,
    output logic [OVF_W-1:0]  ovf_count
);
    ctl_t              ctl_q;
    ctl_t              ctl_w;
    logic              err_q;
    logic              ready;
    logic              fin;
    logic              busy;
    logic              pend;
    logic [CODE_W-1:0] result;

    assign ctl_w = ctl_t'(ctl_wdata);

    // Control register: a request is kept only while the core is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{run: 1'b0, pd: 1'b1, rel: 1'b0};
        end else if (ctl_we) begin
            ctl_q.run <= ctl_w.run && ready;
            ctl_q.pd  <= ctl_w.pd;
            ctl_q.rel <= ctl_w.rel;
        end else begin
            ctl_q.run <= ctl_q.run && ready;
        end
    end

    // Sticky error: records a request made while the core was not ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (ctl_we && ctl_w.run && !ready)
            err_q <= 1'b1;
        else if (err_ack)
            err_q <= 1'b0;
    end

    tsense_pwr #(
        .PU_CYCLES (PU_CYCLES),
        .RST_CYCLES(RST_CYCLES)
    ) u_pwr (
        .clk  (clk),
        .rst_n(rst_n),
        .pd   (ctl_q.pd),
        .rel  (ctl_q.rel),
        .ready(ready)
    );

    tsense_conv #(
        .SAMPLE_CYCLES(SAMPLE_CYCLES)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .run     (ctl_q.run),
        .raw_code(raw_code),
        .fin     (fin),
        .busy    (busy),
        .result  (result)
    );

    tsense_irq #(
        .OVF_W(OVF_W)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .fin  (fin),
        .ack  (irq_ack),
        .pend (pend),
        .ovf  (ovf_count)
    );

    assign sense_pd    = ctl_q.pd;
    assign sense_rst_n = ready;
    assign irq         = pend;
    assign status_word = {4'b0, result, 12'b0, err_q, pend, busy, ready};

    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[2] && !ready) |=> (err_q && !ctl_q.run));
    assert_pd_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pd |=> !ready);

endmodule

// File: tb/tsense_ctrl_test.sv
// Self-checking bench for tsense_ctrl with scaled-down cycle counts.
module tsense_ctrl_test;
    localparam int PU     = 20;
    localparam int RST    = 4;
    localparam int SAMPLE = 16;
    localparam int OVF_W  = 2;
    localparam int NVEC   = 4;
    localparam logic [11:0] VEC [NVEC] = '{12'h0A1, 12'hFFF, 12'h000, 12'h7E5};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [2:0]  ctl_wdata;
    logic        irq_ack;
    logic        err_ack;
    logic [11:0] raw_code;
    logic        sense_pd;
    logic        sense_rst_n;
    logic [31:0] status_word;
    logic        irq;
    logic [OVF_W-1:0] ovf_count;

    int checks = 0;
    int errors = 0;
    logic [11:0] prev;

    always #5 clk = ~clk;

    tsense_ctrl #(
        .PU_CYCLES    (PU),
        .RST_CYCLES   (RST),
        .SAMPLE_CYCLES(SAMPLE),
        .OVF_W        (OVF_W)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .irq_ack    (irq_ack),
        .err_ack    (err_ack),
        .raw_code   (raw_code),
        .sense_pd   (sense_pd),
        .sense_rst_n(sense_rst_n),
        .status_word(status_word),
        .irq        (irq),
        .ovf_count  (ovf_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write lands on the next rising edge; returns on the following falling edge.
    task automatic wr(input logic [2:0] d);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        irq_ack = 1'b0; err_ack = 1'b0; raw_code = '0;
        tick(3);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 status", status_word, 32'h0);
        chk("R1 pd", {31'b0, sense_pd}, 32'd1);
        chk("R1 rst_n", {31'b0, sense_rst_n}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 ovf", {30'b0, ovf_count}, 32'd0);

        // R9 request while not ready, R3 pd bit position
        wr(3'b110);
        chk("R9 err set", {31'b0, status_word[3]}, 32'd1);
        chk("R3 pd held", {31'b0, sense_pd}, 32'd1);

        // R2 power-up and reset hold timing, R3 release bit
        wr(3'b001);
        chk("R3 pd cleared", {31'b0, sense_pd}, 32'd0);
        tick(PU + RST);
        chk("R2 not ready early", {31'b0, status_word[0]}, 32'd0);
        tick(1);
        chk("R2 ready", {31'b0, status_word[0]}, 32'd1);
        chk("R2 core reset released", {31'b0, sense_rst_n}, 32'd1);

        // R9 dropped request never starts later
        tick(SAMPLE + 4);
        chk("R9 no conversion", {30'b0, irq, status_word[1]}, 32'd0);
        chk("R9 err sticky", {31'b0, status_word[3]}, 32'd1);
        err_ack = 1'b1; tick(1); err_ack = 1'b0;
        chk("R9 err cleared", {31'b0, status_word[3]}, 32'd0);

        // R4 R6 R11 single shots from the table
        prev = 12'h000;
        for (int i = 0; i < NVEC; i++) begin
            raw_code = VEC[i];
            wr(3'b101);
            wr(3'b001);
            chk("R11 busy", {31'b0, status_word[1]}, 32'd1);
            tick(SAMPLE - 1);
            chk("R6 result held", {20'b0, status_word[27:16]}, {20'b0, prev});
            chk("R4 no early irq", {31'b0, irq}, 32'd0);
            tick(1);
            chk("R4 result", {20'b0, status_word[27:16]}, {20'b0, VEC[i]});
            chk("R7 irq set", {31'b0, irq}, 32'd1);
            chk("R11 idle", {31'b0, status_word[1]}, 32'd0);
            ack_irq();
            chk("R7 irq cleared", {31'b0, irq}, 32'd0);
            tick(SAMPLE + 2);
            chk("R4 single only", {31'b0, irq}, 32'd0);
            prev = VEC[i];
        end

        // R7 set wins over clear in the same cycle
        raw_code = 12'h5A5;
        wr(3'b101);
        wr(3'b001);
        tick(SAMPLE - 1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R7 set wins", {31'b0, irq}, 32'd1);
        chk("R8 no ovf on ack", {30'b0, ovf_count}, 32'd0);
        ack_irq();

        // R5 R8 continuous run
        raw_code = 12'h111;
        wr(3'b101);
        tick(SAMPLE);
        chk("R6 held before", {20'b0, status_word[27:16]}, 32'h5A5);
        tick(1);
        chk("R5 first", {20'b0, status_word[27:16]}, 32'h111);
        chk("R8 ovf0", {30'b0, ovf_count}, 32'd0);
        raw_code = 12'h222;
        tick(SAMPLE - 1);
        chk("R6 held mid", {20'b0, status_word[27:16]}, 32'h111);
        tick(1);
        chk("R5 second", {20'b0, status_word[27:16]}, 32'h222);
        chk("R8 ovf1", {30'b0, ovf_count}, 32'd1);
        raw_code = 12'h333;
        tick(SAMPLE);
        chk("R5 third", {20'b0, status_word[27:16]}, 32'h333);
        chk("R8 ovf2", {30'b0, ovf_count}, 32'd2);
        raw_code = 12'h444;
        wr(3'b001);
        tick(SAMPLE - 1);
        chk("R4 in-flight completes", {20'b0, status_word[27:16]}, 32'h444);
        chk("R8 ovf3", {30'b0, ovf_count}, 32'd3);
        tick(2 * SAMPLE);
        chk("R5 stopped", {31'b0, status_word[1]}, 32'd0);

        // R8 saturation
        raw_code = 12'h555;
        wr(3'b101);
        wr(3'b001);
        tick(SAMPLE);
        chk("R8 saturate", {30'b0, ovf_count}, 32'd3);
        chk("R7 still set", {31'b0, irq}, 32'd1);
        ack_irq();

        // R10 power-down aborts a running conversion
        raw_code = 12'h123;
        wr(3'b101);
        tick(5);
        wr(3'b011);
        tick(1);
        chk("R10 ready dropped", {31'b0, status_word[0]}, 32'd0);
        chk("R10 pd out", {31'b0, sense_pd}, 32'd1);
        tick(1);
        chk("R10 busy dropped", {31'b0, status_word[1]}, 32'd0);
        tick(SAMPLE + 2);
        chk("R10 no irq", {31'b0, irq}, 32'd0);
        chk("R10 result kept", {20'b0, status_word[27:16]}, 32'h555);

        // R10 request does not resume after re-power
        wr(3'b001);
        tick(PU + RST + 1 + SAMPLE + 2);
        chk("R10 ready again", {31'b0, status_word[0]}, 32'd1);
        chk("R10 no resume", {30'b0, irq, status_word[1]}, 32'd0);

        // R3 return to low power
        wr(3'b010);
        tick(1);
        chk("R3 low power pd", {31'b0, sense_pd}, 32'd1);
        chk("R3 low power rst", {31'b0, sense_rst_n}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule